// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of an I/O peripheral that sits on a byte-wide legacy I/O bus. In normal operation it is in run mode. In that mode it claims no bus cycle, with one exception: it listens for a single unlock byte written to its configuration port address. Once that byte arrives, the block enters configuration mode. The configuration port address then acts as an index port, and the next address up acts as a data port. Together they give access to a small bank of 8-bit configuration registers, and one of those registers drives the logical-device enable outputs.

A strap input is sampled while reset is held, and the last sampled value chooses the initial port base. Two configuration registers hold the low and high byte of the current base. Writing either of them moves both ports at once, and the move takes effect from the next bus cycle. Every decode is gated by the address-enable signal. A cycle that has address-enable high belongs to another bus master and is never claimed.

The bus side uses single-cycle strobes and has no back-pressure. A claimed read always returns its data exactly one clock after the read strobe, with `bus_rvalid` high for that one clock. Claimed writes take effect at the clock edge that samples the strobe. An unclaimed read produces no `bus_rvalid`. An unclaimed write changes nothing.

Top module: `cfg_port_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, the block is in run mode: `cfg_mode` is 0, `dev_en` is all zeros and `bus_rvalid` is 0.
- R2: In run mode, a write of 0x55 to the current base address sets `cfg_mode` to 1 from the next clock.
- R3: In run mode, reads at the base and at base+1 produce no `bus_rvalid`. Writes at base+1 change no register. Writes of any value other than 0x55 at the base leave the block in run mode.
- R4: In configuration mode, a write at the base latches the written byte as the register index. A read at the base returns the latched index.
- R5: In configuration mode, a read at base+1 returns the register selected by the index, and a write at base+1 updates it.
- R6: A strap value of 0 during reset gives base 0x03F0, and a value of 1 gives base 0x0370. Index 0x26 reads the low byte of the base and index 0x27 reads the high byte.
- R7: Writing index 0x26 or 0x27 moves the base from the next cycle. The old addresses then no longer respond.
- R8: Any cycle with `bus_aen` high is ignored: no `bus_rvalid`, no register change and no mode change.
- R9: In configuration mode, a write of 0xAA at the base returns the block to run mode and leaves the latched index unchanged.
- R10: Indices other than 0x26, 0x27 and 0x30 read as 0x00, and writes to them are discarded.
- R11: Index 0x30 holds the device enables. Bit i drives `dev_en[i]`, and bits at or above NDEV read as 0.
- R12: A claimed read raises `bus_rvalid` with `bus_rdata` for exactly the one clock that follows the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap | input | 1 | Base-select strap, sampled while reset is held |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_aen | input | 1 | Address enable; high means the cycle is not claimed |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a claimed read |
| cfg_mode | output | 1 | 1 while in configuration mode |
| dev_en | output | NDEV | Logical-device enables |

## Verification
The hardest state to reach is a moved base. From there the bench has to show three things: the old index and data addresses have gone silent, the new ones answer, and the unlock key is recognised only at the new address. It gets there with a directed sequence. First the low byte is rewritten, which leaves a mixed base built from the new low byte and the old high byte. Then the high byte is rewritten at that mixed base. The bench also repeats the whole reset with the opposite strap value, so that both base choices are reached. Random index and data traffic, with occasional address-enable cycles mixed in, exercises the implemented registers and the unimplemented ones against a bench-side model.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] KEY_ENTER   = 8'h55;
  localparam logic [DW-1:0] KEY_EXIT    = 8'hAA;
  localparam logic [DW-1:0] IDX_BASE_LO = 8'h26;
  localparam logic [DW-1:0] IDX_BASE_HI = 8'h27;
  localparam logic [DW-1:0] IDX_DEV_EN  = 8'h30;
  localparam logic [AW-1:0] BASE_STRAP0 = 16'h03F0;
  localparam logic [AW-1:0] BASE_STRAP1 = 16'h0370;

  typedef struct packed {
    logic idx;  // base address hit
    logic dat;  // base+1 hit
  } hit_t;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          aen,
  input  logic [AW-1:0] base,
  output hit_t          hit
);
  logic [AW-1:0] base_p1;
  assign base_p1 = base + AW'(1);

  always_comb begin
    hit.idx = !aen && (addr == base);
    hit.dat = !aen && (addr == base_p1);
  end
endmodule

// File: rtl/cfgp_mode.sv
module cfgp_mode
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  hit_t          hit,
  output logic          cfg_mode,
  output logic          idx_we
);
  typedef enum logic {ST_RUN, ST_CFG} mode_e;
  mode_e st;

  logic key_wr;
  assign key_wr   = wr && hit.idx;
  assign cfg_mode = (st == ST_CFG);
  assign idx_we   = key_wr && (st == ST_CFG) && (wdata != KEY_EXIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RUN;
    end else if (key_wr) begin
      if (st == ST_RUN && wdata == KEY_ENTER) st <= ST_CFG;
      else if (st == ST_CFG && wdata == KEY_EXIT) st <= ST_RUN;
    end
  end
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
#(
  parameter int unsigned NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap,
  input  logic            idx_we,
  input  logic            dat_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   index,
  output logic [DW-1:0]   sel_val,
  output logic [AW-1:0]   base,
  output logic [NDEV-1:0] dev_en
);
  localparam int unsigned HB = AW / 2;
  logic [DW-1:0] en_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index  <= '0;
      base   <= strap ? BASE_STRAP1 : BASE_STRAP0;
      dev_en <= '0;
    end else begin
      if (idx_we) index <= wdata;
      if (dat_we) begin
        unique case (index)
          IDX_BASE_LO: base[HB-1:0]  <= wdata;
          IDX_BASE_HI: base[AW-1:HB] <= wdata;
          IDX_DEV_EN:  dev_en        <= wdata[NDEV-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_en_rd
    if (i < NDEV) begin : g_live
      assign en_rd[i] = dev_en[i];
    end else begin : g_zero
      assign en_rd[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (index)
      IDX_BASE_LO: sel_val = base[HB-1:0];
      IDX_BASE_HI: sel_val = base[AW-1:HB];
      IDX_DEV_EN:  sel_val = en_rd;
      default:     sel_val = '0;
    endcase
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfgp_pkg::*;
#(
  parameter int unsigned NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap,
  input  logic [15:0]     bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_aen,
  output logic [7:0]      bus_rdata,
  output logic            bus_rvalid,
  output logic            cfg_mode,
  output logic [NDEV-1:0] dev_en
);
  hit_t          hit;
  logic [AW-1:0] base;
  logic [DW-1:0] index, sel_val;
  logic          idx_we, dat_we, rd_claim;

  cfgp_decode u_dec (
    .addr(bus_addr), .aen(bus_aen), .base(base), .hit(hit)
  );

  cfgp_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .hit(hit), .cfg_mode(cfg_mode), .idx_we(idx_we)
  );

  assign dat_we   = bus_wr && hit.dat && cfg_mode;
  assign rd_claim = bus_rd && cfg_mode && (hit.idx || hit.dat);

  cfgp_regfile #(.NDEV(NDEV)) u_rf (
    .clk(clk), .rst_n(rst_n), .strap(strap), .idx_we(idx_we),
    .dat_we(dat_we), .wdata(bus_wdata), .index(index),
    .sel_val(sel_val), .base(base), .dev_en(dev_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_claim;
      if (rd_claim) bus_rdata <= hit.idx ? index : sel_val;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int unsigned NDEV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_wdata,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            bus_aen,
  input logic            bus_rvalid,
  input logic            cfg_mode,
  input logic [NDEV-1:0] dev_en
);
  // R12
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd && !bus_aen && cfg_mode));
  // R8
  aen_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_aen && !bus_rd) |=> ($stable(cfg_mode) && $stable(dev_en) && !bus_rvalid));
  // R3
  run_stays_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !(bus_wr && bus_wdata == 8'h55)) |=> !cfg_mode);
  // R3
  run_en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(dev_en));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!cfg_mode && dev_en == '0 && !bus_rvalid));
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_aen(bus_aen), .bus_rvalid(bus_rvalid),
  .cfg_mode(cfg_mode), .dev_en(dev_en)
);

// File: tb/test_cfg_port_ctrl.sv
`timescale 1ns/1ps
module test_cfg_port_ctrl;
  localparam int NDEV = 8;
  logic clk = 0, rst_n = 0, strap = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, bus_aen = 0, bus_rvalid, cfg_mode;
  logic [NDEV-1:0] dev_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_port_ctrl #(.NDEV(NDEV)) i_cfg_port_ctrl (.*);

  function automatic logic [7:0] exp_reg(logic [7:0] idx, logic [15:0] b, logic [7:0] en);
    case (idx)
      8'h26: return b[7:0];
      8'h27: return b[15:8];
      8'h30: return en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, logic aen = 0);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_aen = aen; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_aen = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d, output logic v, input logic aen = 0);
    @(negedge clk); bus_addr = a; bus_aen = aen; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_aen = 0; v = bus_rvalid; d = bus_rdata;
    @(negedge clk); check("R12 rvalid one cycle", {15'd0, bus_rvalid}, 16'd0);
  endtask

  task automatic do_reset(logic s);
    @(negedge clk); rst_n = 0; strap = ~s;
    repeat (2) @(negedge clk);
    strap = s;
    @(negedge clk);
    check("R1 cfg_mode in reset", {15'd0, cfg_mode}, 16'd0);
    rst_n = 1; strap = ~s;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic v;
    logic [15:0] base;
    logic [7:0] m_en, idx;
    void'($urandom(32'd4711));

    // strap = 1 first
    do_reset(1'b1);
    base = 16'h0370;
    check("R1 cfg_mode", {15'd0, cfg_mode}, 0);
    check("R1 dev_en", {8'd0, dev_en}, 0);
    check("R1 rvalid", {15'd0, bus_rvalid}, 0);
    rd(base, d, v); check("R3 run read base no rvalid", {15'd0, v}, 0);
    rd(base + 1, d, v); check("R3 run read data no rvalid", {15'd0, v}, 0);
    wr(base, 8'h54); check("R3 wrong key stays run", {15'd0, cfg_mode}, 0);
    wr(16'h03F0, 8'h55); check("R6 strap1 ignores 0x3F0", {15'd0, cfg_mode}, 0);
    wr(base, 8'h55, 1'b1); check("R8 aen key ignored", {15'd0, cfg_mode}, 0);
    wr(base, 8'h55); check("R2 enter cfg", {15'd0, cfg_mode}, 1);
    wr(base, 8'h26); rd(base + 1, d, v);
    check("R6 base lo strap1 valid", {15'd0, v}, 1);
    check("R6 base lo strap1", {8'd0, d}, 16'h70);
    wr(base, 8'h27); rd(base + 1, d, v);
    check("R6 base hi strap1", {8'd0, d}, 16'h03);
    rd(base, d, v); check("R4 index readback", {8'd0, d}, 16'h27);

    // strap = 0
    do_reset(1'b0);
    base = 16'h03F0; m_en = 0;
    check("R1 cfg_mode after reset", {15'd0, cfg_mode}, 0);
    wr(base + 1, 8'hFF); // run-mode data write ignored
    wr(base, 8'h55); check("R2 enter cfg strap0", {15'd0, cfg_mode}, 1);
    wr(base, 8'h30); rd(base + 1, d, v);
    check("R3 run data write ignored", {8'd0, d}, 16'h00);
    wr(base + 1, 8'hA5);
    check("R11 dev_en drive", {8'd0, dev_en}, 16'hA5); m_en = 8'hA5;
    wr(base + 1, 8'h0F, 1'b1);
    check("R8 aen data write ignored", {8'd0, dev_en}, 16'hA5);
    rd(base + 1, d, v, 1'b1); check("R8 aen read no rvalid", {15'd0, v}, 0);
    wr(base, 8'h26); rd(base + 1, d, v);
    check("R6 base lo strap0", {8'd0, d}, 16'hF0);
    wr(base, 8'h13); wr(base + 1, 8'h77); rd(base + 1, d, v);
    check("R10 unimpl reads zero", {8'd0, d}, 16'h00);
    check("R10 unimpl write no effect", {8'd0, dev_en}, 16'hA5);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if (r == 8'h26 || r == 8'h27 || r == 8'hAA) r = 8'h30;
      idx = r;
      wr(base, idx);
      if ($urandom % 2) begin
        r = 8'($urandom);
        if ($urandom % 5 == 0) wr(base + 1, r, 1'b1);
        else begin
          wr(base + 1, r);
          if (idx == 8'h30) m_en = r;
        end
      end
      rd(base + 1, d, v);
      check(idx == 8'h30 ? "R5 R11 random en" : "R10 random unimpl", {7'd0, v, d},
            {8'd1, exp_reg(idx, base, m_en)});
      check("R11 random dev_en", {8'd0, dev_en}, {8'd0, m_en});
    end

    // relocation
    wr(base, 8'h26); wr(base + 1, 8'h80); base = 16'h0380;
    rd(16'h03F0, d, v); check("R7 old base silent", {15'd0, v}, 0);
    rd(base, d, v); check("R7 mixed base index", {7'd0, v, d}, 16'h0126);
    wr(base, 8'h27); wr(base + 1, 8'h02); base = 16'h0280;
    rd(16'h0381, d, v); check("R7 mid base silent", {15'd0, v}, 0);
    rd(base + 1, d, v); check("R7 new base hi", {7'd0, v, d}, 16'h0102);

    // exit
    wr(base, 8'hAA); check("R9 exit", {15'd0, cfg_mode}, 0);
    rd(base, d, v); check("R9 run after exit no rvalid", {15'd0, v}, 0);
    wr(16'h03F0, 8'h55); check("R7 key at old base ignored", {15'd0, cfg_mode}, 0);
    wr(base, 8'h55); check("R7 key at new base", {15'd0, cfg_mode}, 1);
    rd(base, d, v); check("R9 index kept over exit", {8'd0, d}, 16'h27);
    wr(base, 8'h55); rd(base, d, v);
    check("R4 0x55 in cfg latches index", {8'd0, d}, 16'h55);
    check("R4 still cfg", {15'd0, cfg_mode}, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule